// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block collects eight event strobes from a bus controller and turns them into one interrupt line. Each event sets a sticky bit in a status register. Software clears a bit by writing a one to it. A per-source enable register selects which sticky bits may raise the interrupt. A single master-enable bit then gates the combined request. The interrupt output is a registered level: it rises one clock after an enabled, pending source appears, and it drops one clock after the last such source is cleared or masked.

The same register port also holds a soft-reset register. A write of the exact key value clears status, enables and the master enable. The same write also sends a one-cycle reset pulse to the rest of the controller. Writes of any other value to that register do nothing. Software uses the port with single-cycle writes. Reads return data on the clock after the request.

Top module: `intr_status_unit`

## Requirements
- R1: After the synchronous reset, every register reads as zero, `irq_o` is low and `ctrl_rst_o` is low.
- R2: An event input that is high at a rising clock edge sets its status bit at offset 0x20. The bit stays set after the event drops, until it is cleared or a soft reset occurs. Bit map: 0 arbitration lost, 1 transmit error/complete, 2 transmit empty, 3 receive watermark, 4 bus idle, 5 addressed as target, 6 no longer addressed, 7 transmit half empty.
- R3: A write to the status register clears every bit written as one and leaves every bit written as zero unchanged.
- R4: If a status bit's event is high in the same cycle as a write that clears it, the bit stays set.
- R5: The enable register at offset 0x28 stores bits 7:0 of a write and reads back those bits, with bits 31:8 reading zero.
- R6: The master-enable register at offset 0x1C stores only bit 31 of a write. It reads back that bit, with bits 30:0 reading zero.
- R7: `irq_o` is high in a cycle exactly when, at the previous clock edge, the master enable was set and some status bit was set whose enable bit was also set.
- R8: A write of 0x0000000A to the soft-reset register at offset 0x40 clears status, enables and master enable at that edge. It also drives `ctrl_rst_o` high for exactly the following cycle.
- R9: A write of any other value to offset 0x40 changes no register and leaves `ctrl_rst_o` low. Offset 0x40 always reads zero.
- R10: A write to an unmapped offset changes no register, and a read of an unmapped offset returns zero.
- R11: A status write can never set a status bit. Writing ones to bits that are clear leaves them clear.
- R12: A read request returns the addressed register's value on `rdata_o` one cycle later. `rdata_o` holds that value until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| evt_i | input | 8 | Event sources, one per status bit |
| irq_o | output | 1 | Registered interrupt level |
| ctrl_rst_o | output | 1 | One-cycle soft-reset pulse to the controller |

## Verification
The events are driven in several patterns:
- A single-bit pulse, then a two-bit pulse at opposite ends of the vector, to show that bits are sticky and independent.
- Clearing writes with mixed one/zero masks, to tell write-one-to-clear apart from a plain store.
- A write of ones over clear bits, to show that a status write cannot set a bit.
- A clear write that coincides with its own event, to show that the set wins.

The interrupt line is tried with the master enable off, with an enabled but non-pending source, and with an enabled pending source. This tells the two gating terms apart. The soft-reset register receives the key, a near-miss value sharing the low nibble, and an unrelated value, to show that only the exact key has an effect.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int unsigned SRC_COUNT = 8;
    localparam int unsigned WORD_W    = 32;

    localparam logic [7:0] OFF_MASTER = 8'h1C;
    localparam logic [7:0] OFF_STATUS = 8'h20;
    localparam logic [7:0] OFF_ENABLE = 8'h28;
    localparam logic [7:0] OFF_SRESET = 8'h40;

    localparam logic [WORD_W-1:0] SRESET_KEY = 32'h0000_000A;

    // Bit positions of the event sources inside the status word.
    typedef enum logic [2:0] {
        SRC_ARB_LOST  = 3'd0,
        SRC_TX_FAULT  = 3'd1,
        SRC_TX_EMPTY  = 3'd2,
        SRC_RX_LEVEL  = 3'd3,
        SRC_BUS_IDLE  = 3'd4,
        SRC_ADDR_HIT  = 3'd5,
        SRC_ADDR_MISS = 3'd6,
        SRC_TX_HALF   = 3'd7
    } src_idx_e;

    // One-hot register select, shared by the write and read paths.
    typedef struct packed {
        logic master;
        logic status;
        logic enable;
        logic sreset;
    } reg_sel_t;

    function automatic logic any_pending(input logic [SRC_COUNT-1:0] sts,
                                         input logic [SRC_COUNT-1:0] ena);
        return |(sts & ena);
    endfunction

    function automatic logic key_match(input logic [WORD_W-1:0] data,
                                       input logic [WORD_W-1:0] key);
        return data == key;
    endfunction

endpackage

// File: rtl/isu_decode.sv
module isu_decode
    import isu_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          wsel_o,
    output reg_sel_t          rsel_o
);

    reg_sel_t hit;

    always_comb begin
        hit.master = (addr_i == ADDR_W'(OFF_MASTER));
        hit.status = (addr_i == ADDR_W'(OFF_STATUS));
        hit.enable = (addr_i == ADDR_W'(OFF_ENABLE));
        hit.sreset = (addr_i == ADDR_W'(OFF_SRESET));
    end

    always_comb begin
        wsel_o = wr_en_i ? hit : '0;
        rsel_o = rd_en_i ? hit : '0;
    end

endmodule

// File: rtl/isu_status.sv
module isu_status
    import isu_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] clr_mask_i,
    input  logic            sreset_i,
    input  logic [NSRC-1:0] evt_i,
    output logic [NSRC-1:0] status_o
);

    logic [NSRC-1:0] sts_q;
    logic [NSRC-1:0] clr;

    assign clr = clr_wr_i ? clr_mask_i : '0;

    // Each bit is its own sticky cell; set has priority over clear.
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (rst_i || sreset_i)
                sts_q[i] <= 1'b0;
            else if (evt_i[i])
                sts_q[i] <= 1'b1;
            else if (clr[i])
                sts_q[i] <= 1'b0;
        end
    end

    assign status_o = sts_q;

    // R2: a set bit only drops through a clear or a soft reset
    a_r2_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        !sreset_i |=> ((($past(sts_q) & ~$past(clr)) & ~sts_q) == '0));

    // R3: a cleared bit without a coincident event reads zero afterwards
    a_r3_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        !sreset_i |=> ((sts_q & $past(clr & ~evt_i)) == '0));

    // R4: an event always lands, even against a clear write
    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        !sreset_i |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/isu_ctrl.sv
module isu_ctrl
    import isu_pkg::*;
#(
    parameter int unsigned        NSRC   = SRC_COUNT,
    parameter int unsigned        DATA_W = WORD_W,
    parameter logic [DATA_W-1:0]  KEY    = SRESET_KEY
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  reg_sel_t          wsel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              sreset_o,
    output logic [NSRC-1:0]   enable_o,
    output logic              master_o,
    output logic              ctrl_rst_o
);

    localparam int unsigned MASTER_BIT = DATA_W - 1;

    logic [NSRC-1:0] ena_q;
    logic            mst_q;
    logic            pulse_q;
    logic            hit;

    assign hit = wsel_i.sreset && key_match(wdata_i, KEY);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ena_q   <= '0;
            mst_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (hit) begin
                ena_q <= '0;
                mst_q <= 1'b0;
            end else begin
                if (wsel_i.enable) ena_q <= wdata_i[NSRC-1:0];
                if (wsel_i.master) mst_q <= wdata_i[MASTER_BIT];
            end
        end
    end

    assign sreset_o   = hit;
    assign enable_o   = ena_q;
    assign master_o   = mst_q;
    assign ctrl_rst_o = pulse_q;

    // R8: the key clears the control state and pulses the reset output
    a_r8_key: assert property (@(posedge clk_i) disable iff (rst_i)
        (wsel_i.sreset && wdata_i == KEY) |=> (ctrl_rst_o && enable_o == '0 && !master_o));

    // R9: any other value at the reset offset changes nothing
    a_r9_nokey: assert property (@(posedge clk_i) disable iff (rst_i)
        (wsel_i.sreset && wdata_i != KEY) |=> (!ctrl_rst_o && $stable(enable_o) && $stable(master_o)));

endmodule

// File: rtl/isu_irq.sv
module isu_irq
    import isu_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] status_i,
    input  logic [NSRC-1:0] enable_i,
    input  logic            master_i,
    output logic            irq_o
);

    logic irq_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_q <= 1'b0;
        else       irq_q <= master_i && any_pending(status_i, enable_i);
    end

    assign irq_o = irq_q;

    // R7: the master enable gates the line
    a_r7_master: assert property (@(posedge clk_i) disable iff (rst_i)
        !master_i |=> !irq_o);

    // R7: nothing pending means no interrupt next cycle
    a_r7_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        ((status_i & enable_i) == '0) |=> !irq_o);

endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
    import isu_pkg::*;
#(
    parameter int unsigned       ADDR_W = 8,
    parameter int unsigned       DATA_W = WORD_W,
    parameter int unsigned       NSRC   = SRC_COUNT,
    parameter logic [DATA_W-1:0] KEY    = SRESET_KEY
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [NSRC-1:0]   evt_i,
    output logic              irq_o,
    output logic              ctrl_rst_o
);

    localparam int unsigned PAD_W = DATA_W - NSRC;

    reg_sel_t          wsel;
    reg_sel_t          rsel;
    logic              sreset;
    logic [NSRC-1:0]   status;
    logic [NSRC-1:0]   enable;
    logic              master;
    logic [DATA_W-1:0] rmux;
    logic [DATA_W-1:0] rdata_q;

    isu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wsel_o  (wsel),
        .rsel_o  (rsel)
    );

    isu_ctrl #(.NSRC(NSRC), .DATA_W(DATA_W), .KEY(KEY)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wsel_i     (wsel),
        .wdata_i    (wdata_i),
        .sreset_o   (sreset),
        .enable_o   (enable),
        .master_o   (master),
        .ctrl_rst_o (ctrl_rst_o)
    );

    isu_status #(.NSRC(NSRC)) u_status (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_wr_i   (wsel.status),
        .clr_mask_i (wdata_i[NSRC-1:0]),
        .sreset_i   (sreset),
        .evt_i      (evt_i),
        .status_o   (status)
    );

    isu_irq #(.NSRC(NSRC)) u_irq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .status_i (status),
        .enable_i (enable),
        .master_i (master),
        .irq_o    (irq_o)
    );

    // Read mux; the reset register and unmapped offsets return zero.
    always_comb begin
        rmux = '0;
        if (rsel.master) rmux = {master, {(DATA_W-1){1'b0}}};
        if (rsel.status) rmux = {{PAD_W{1'b0}}, status};
        if (rsel.enable) rmux = {{PAD_W{1'b0}}, enable};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rmux;
    end

    assign rdata_o = rdata_q;

    // R12: read data is held between read requests
    a_r12_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> $stable(rdata_o));

    // R9: the reset register never returns data
    a_r9_readzero: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && addr_i == ADDR_W'(OFF_SRESET)) |=> (rdata_o == '0));

    // R8: the controller reset pulse lasts one cycle
    a_r8_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_rst_o && !(wr_en_i && addr_i == ADDR_W'(OFF_SRESET) && wdata_i == KEY))
        |=> !ctrl_rst_o);

endmodule

// File: tb/intr_status_unit_tb.sv
module intr_status_unit_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_MST = 8'h1C;
    localparam logic [7:0] A_STS = 8'h20;
    localparam logic [7:0] A_ENA = 8'h28;
    localparam logic [7:0] A_RST = 8'h40;
    localparam logic [7:0] A_GAP = 8'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  evt = '0;
    logic        irq;
    logic        crst;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic rd_d = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_status_unit u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .evt_i      (evt),
        .irq_o      (irq),
        .ctrl_rst_o (crst)
    );

    always @(posedge clk) rd_d <= rd_en;

    // Monitor: pops the expected read value one cycle after each request.
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata actual 0x%08h expected 0x%08h", t, rdata, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; evt = ev;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        evt = ev;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic chk(input logic act, input logic e, input string t);
        tests++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", t, act, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(irq, 1'b0, "R1 irq after reset");
        chk(crst, 1'b0, "R1 ctrl_rst after reset");
        rd(A_MST, 32'h0, "R1 master");
        rd(A_STS, 32'h0, "R1 status");
        rd(A_ENA, 32'h0, "R1 enable");

        // R2: sticky events, bits 2 then 0 and 7
        pulse(8'h04);
        rd(A_STS, 32'h04, "R2 single event");
        pulse(8'h81);
        rd(A_STS, 32'h85, "R2 two events");

        // R3: write-one-to-clear, zero leaves bits alone
        wr(A_STS, 32'h04, 8'h00);
        rd(A_STS, 32'h81, "R3 clear bit2");
        wr(A_STS, 32'h00, 8'h00);
        rd(A_STS, 32'h81, "R3 zero write");

        // R11: ones over clear bits do not set them
        wr(A_STS, 32'h7E, 8'h00);
        rd(A_STS, 32'h81, "R11 no set by write");

        // R4: event and clear together
        wr(A_STS, 32'h01, 8'h01);
        rd(A_STS, 32'h81, "R4 set wins");

        // R5, R6: register widths
        wr(A_ENA, 32'hFFFF_FF01, 8'h00);
        rd(A_ENA, 32'h01, "R5 enable width");
        chk(irq, 1'b0, "R7 master off");
        wr(A_MST, 32'hFFFF_FFFF, 8'h00);
        rd(A_MST, 32'h8000_0000, "R6 master bit only");

        // R7: gating
        chk(irq, 1'b1, "R7 enabled pending");
        wr(A_STS, 32'h01, 8'h00);
        tick();
        chk(irq, 1'b0, "R7 enabled source cleared");
        wr(A_ENA, 32'h80, 8'h00);
        tick();
        chk(irq, 1'b1, "R7 other source enabled");
        wr(A_MST, 32'h7FFF_FFFF, 8'h00);
        tick();
        chk(irq, 1'b0, "R7 master cleared");
        wr(A_MST, 32'h8000_0000, 8'h00);
        tick();
        chk(irq, 1'b1, "R7 master restored");

        // R9: non-key values
        wr(A_RST, 32'h0000_0005, 8'h00);
        chk(crst, 1'b0, "R9 value 5 pulse");
        wr(A_RST, 32'h0000_001A, 8'h00);
        chk(crst, 1'b0, "R9 value 1A pulse");
        rd(A_RST, 32'h0, "R9 reads zero");
        rd(A_ENA, 32'h80, "R9 enable kept");
        rd(A_STS, 32'h80, "R9 status kept");
        chk(irq, 1'b1, "R9 irq kept");

        // R10: unmapped offset
        wr(A_GAP, 32'hFFFF_FFFF, 8'h00);
        rd(A_GAP, 32'h0, "R10 unmapped read");
        rd(A_STS, 32'h80, "R10 status untouched");
        rd(A_MST, 32'h8000_0000, "R10 master untouched");

        // R12: data held after read
        tick();
        tick();
        tests++;
        if (rdata !== 32'h8000_0000) begin
            fails++;
            $display("FAIL R12 hold: actual 0x%08h expected 0x80000000", rdata);
        end

        // R8: key
        wr(A_RST, 32'h0000_000A, 8'h00);
        chk(crst, 1'b1, "R8 pulse high");
        tick();
        chk(crst, 1'b0, "R8 pulse one cycle");
        chk(irq, 1'b0, "R8 irq dropped");
        rd(A_STS, 32'h0, "R8 status cleared");
        rd(A_ENA, 32'h0, "R8 enable cleared");
        rd(A_MST, 32'h0, "R8 master cleared");

        tick();
        tick();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule